// File: doc/BRIEF.md
# Destructive Reset Cause Recorder

This block keeps a record of which destructive event caused the most recent reset. It watches five detector outputs: power-on, a high-rail low-voltage detector, a watchdog timeout, and core-rail low-voltage detectors for two power domains. Each detected event sets a sticky status flag and raises one request to the rest of the chip: reset, safe mode or interrupt.

Software reads the five flags and clears them with write-one-to-clear. When the power-up is non-monotonic, a power-on event can be followed by a low-voltage event. Any low-voltage event wipes the power-on flag. Software should therefore read any of the supply flags as evidence of a power-on. The domain-0 core-rail detector is captured when its signal drops, not when it rises. Per-source configuration inputs pick either a reset request or an alternate reaction for each source. The power-on source and the high-rail source are fixed to reset.

All five-bit vectors (status, clear data, alternate select, alternate kind) use the same bit map: bit 0 power-on, bit 1 high-rail low voltage, bit 2 watchdog, bit 3 core-rail low voltage domain 1, bit 4 core-rail low voltage domain 0.

Top module: `rst_cause_rec`

## Requirements
- R1: Five flags appear on `status`: bit 0 power-on, bit 1 high-rail low voltage, bit 2 watchdog, bit 3 core domain 1 low voltage, bit 4 core domain 0 low voltage. After `rst_n` is released, all three requests are 0.
- R2: A flag that is 1 stays 1 until a software clear of that bit, a power-on event, or (for bit 0 only) a low-voltage event removes it.
- R3: A power-on event sets bit 0 and clears bits 1 to 4, unless a low-voltage event is captured in the same cycle.
- R4: A captured event on bit 1, 3 or 4 clears bit 0.
- R5: A write (`sw_clr_wr` = 1) clears every flag whose bit in `sw_clr_data` is 1 and leaves the others unchanged.
- R6: The domain-0 core event (bit 4) is captured when `clv0_evt` falls. Its flag and its request (reset, or the alternate reaction) appear on that fall. Its rise has no effect.
- R7: Sources 0 to 3 are captured on the rising edge of their input. A level that is held high is captured once.
- R8: For sources 2 to 4, `alt_sel` = 1 replaces the reset request with the alternate reaction: `alt_kind` = 0 gives `safe_req` and `alt_kind` = 1 gives `irq_req`. With `alt_sel` = 0 the source requests reset.
- R9: Sources 0 and 1 always request reset, whatever their `alt_sel` and `alt_kind` bits hold.
- R10: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends at 1.
- R11: `rst_n` does not change the flags. Only a power-on event resets them.
- R12: Each captured event updates its flag and pulses its request for exactly one cycle, at the clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset for the edge detectors and the requests |
| por_evt | input | 1 | Power-on detector output |
| hv_lv_evt | input | 1 | High-rail low-voltage detector output |
| wdog_evt | input | 1 | Watchdog timeout output |
| clv1_evt | input | 1 | Core-rail low-voltage detector, domain 1 |
| clv0_evt | input | 1 | Core-rail low-voltage detector, domain 0 (captured on its fall) |
| sw_clr_wr | input | 1 | Software write strobe for the clear |
| sw_clr_data | input | 5 | Write-one-to-clear mask |
| alt_sel | input | 5 | Per-source choice of the alternate reaction instead of reset |
| alt_kind | input | 5 | Per-source alternate kind: 0 safe mode, 1 interrupt |
| status | output | 5 | Sticky cause flags |
| reset_req | output | 1 | One-cycle reset request |
| safe_req | output | 1 | One-cycle safe-mode request |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The bench drives a power-on followed by a high-rail dip. A design that did not let a low-voltage event clear the power-on flag would report both causes instead of only the low-voltage one. It drives the domain-0 core input up and then down. A design that captured it on the rising edge would set the flag and raise the request one phase early, and a wrong choice of edge would also put the safe request at the wrong time. A clear and a set that collide on one bit, a watchdog input held high, setting the alternate bits on the fixed-reset sources, and pulsing `rst_n` with flags set are each aimed at a specific failure: a lost flag, a repeated capture, a missing reset request, or flags wiped by the wrong reset.

// File: rtl/rcr_pkg.sv
// Shared constants for the reset cause recorder: source count and bit map.
package rcr_pkg;
    localparam int NSRC     = 5;
    localparam int B_POR    = 0;
    localparam int B_HVLV   = 1;
    localparam int B_WDOG   = 2;
    localparam int B_CLV1   = 3;
    localparam int B_CLV0   = 4;
    // sources whose event removes the power-on flag
    localparam logic [NSRC-1:0] LV_MASK   = (1 << B_HVLV) | (1 << B_CLV1) | (1 << B_CLV0);
    // sources captured on the falling edge of their input
    localparam logic [NSRC-1:0] FALL_MASK = (1 << B_CLV0);
    // sources that always request reset
    localparam logic [NSRC-1:0] FIXED_RST = (1 << B_POR) | (1 << B_HVLV);
endpackage

// File: rtl/rcr_edge_cap.sv
// Edge capture for the detector inputs.
// Gives a one-cycle hit for each source, on the rise or (per FALL) on the fall.
// Assumes the inputs are already synchronous to clk.
module rcr_edge_cap #(
    parameter int            N    = 5,
    parameter logic [N-1:0]  FALL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev;

    // remember last cycle's input levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // pick the edge polarity per source
    for (genvar i = 0; i < N; i++) begin : g_edge
        if (FALL[i]) begin : g_fall
            assign hit[i] = prev[i] & ~lvl[i];
        end else begin : g_rise
            assign hit[i] = lvl[i] & ~prev[i];
        end
    end
endmodule

// File: rtl/rcr_flag_reg.sv
// Sticky cause flags with write-one-to-clear.
// Power-on hit clears all flags and sets its own; a low-voltage hit drops the
// power-on flag; a set beats a clear. Reset only through the power-on hit.
module rcr_flag_reg #(
    parameter int           N       = 5,
    parameter int           POR_BIT = 0,
    parameter logic [N-1:0] LV      = '0
) (
    input  logic         clk,
    input  logic [N-1:0] hit,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] keep;
    logic [N-1:0] nxt;
    logic         lv_any;

    // next flag value from hits and software clears
    always_comb begin
        lv_any = |(hit & LV);
        keep   = hit[POR_BIT] ? '0 : flags;
        if (clr_wr) keep = keep & ~clr_mask;
        nxt = keep | hit;
        if (lv_any) nxt[POR_BIT] = 1'b0;
    end

    // flag storage, deliberately outside rst_n
    always_ff @(posedge clk) begin
        flags <= nxt;
    end
endmodule

// File: rtl/rcr_react.sv
// Per-source reaction routing: reset, safe-mode or interrupt request.
// Sources in FIXED always request reset. Requests are one-cycle pulses.
module rcr_react #(
    parameter int           N     = 5,
    parameter logic [N-1:0] FIXED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] alt_sel,
    input  logic [N-1:0] alt_kind,
    output logic         reset_req,
    output logic         safe_req,
    output logic         irq_req
);
    logic [N-1:0] alt_eff;

    // alternate only where the source allows it
    always_comb alt_eff = alt_sel & ~FIXED;

    // register the request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            safe_req  <= 1'b0;
            irq_req   <= 1'b0;
        end else begin
            reset_req <= |(hit & ~alt_eff);
            safe_req  <= |(hit & alt_eff & ~alt_kind);
            irq_req   <= |(hit & alt_eff & alt_kind);
        end
    end
endmodule

// File: rtl/rst_cause_rec.sv
// Top of the destructive reset cause recorder.
// Collects detector inputs, captures edges, holds sticky flags and routes
// each event to a reset, safe-mode or interrupt request.
// Assumes a power-on event arrives before the flags are read.
module rst_cause_rec
    import rcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_evt,
    input  logic            hv_lv_evt,
    input  logic            wdog_evt,
    input  logic            clv1_evt,
    input  logic            clv0_evt,
    input  logic            sw_clr_wr,
    input  logic [NSRC-1:0] sw_clr_data,
    input  logic [NSRC-1:0] alt_sel,
    input  logic [NSRC-1:0] alt_kind,
    output logic [NSRC-1:0] status,
    output logic            reset_req,
    output logic            safe_req,
    output logic            irq_req
);
    logic [NSRC-1:0] evt_lvl;
    logic [NSRC-1:0] evt_hit;

    // pack the detector inputs in the status bit order
    always_comb begin
        evt_lvl         = '0;
        evt_lvl[B_POR]  = por_evt;
        evt_lvl[B_HVLV] = hv_lv_evt;
        evt_lvl[B_WDOG] = wdog_evt;
        evt_lvl[B_CLV1] = clv1_evt;
        evt_lvl[B_CLV0] = clv0_evt;
    end

    rcr_edge_cap #(.N(NSRC), .FALL(FALL_MASK)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (evt_lvl),
        .hit   (evt_hit)
    );

    rcr_flag_reg #(.N(NSRC), .POR_BIT(B_POR), .LV(LV_MASK)) u_flags (
        .clk      (clk),
        .hit      (evt_hit),
        .clr_wr   (sw_clr_wr),
        .clr_mask (sw_clr_data),
        .flags    (status)
    );

    rcr_react #(.N(NSRC), .FIXED(FIXED_RST)) u_react (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (evt_hit),
        .alt_sel   (alt_sel),
        .alt_kind  (alt_kind),
        .reset_req (reset_req),
        .safe_req  (safe_req),
        .irq_req   (irq_req)
    );
endmodule

// File: rtl/rcr_checker.sv
// Property checker for rst_cause_rec, attached with bind below.
// Relates the captured hits, the software clears and the outputs over time.
module rcr_checker
    import rcr_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            clv0_evt,
    input logic            sw_clr_wr,
    input logic [NSRC-1:0] sw_clr_data,
    input logic [NSRC-1:0] hit,
    input logic [NSRC-1:0] status,
    input logic            reset_req
);
    logic lv_hit;
    always_comb lv_hit = |(hit & LV_MASK);

    // R3: power-on without a low-voltage hit leaves only bit 0
    a_r3_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[B_POR] && !lv_hit) |=> (status == NSRC'(1 << B_POR)));

    // R4: any low-voltage hit drops the power-on flag
    a_r4_lv_clears_por: assert property (@(posedge clk) disable iff (!rst_n)
        lv_hit |=> !status[B_POR]);

    // R6: the domain-0 flag follows the fall of its input
    a_r6_clv0_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clv0_evt) && !clv0_evt) |=> status[B_CLV0]);

    // R9: power-on and high-rail always request reset
    a_r9_fixed_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[B_POR] || hit[B_HVLV]) |=> reset_req);

    // R2 and R10 per flag other than power-on
    for (genvar i = 1; i < NSRC; i++) begin : g_bit
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(sw_clr_wr && sw_clr_data[i]) && !hit[B_POR])
            |=> status[i]);
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && sw_clr_wr && sw_clr_data[i]) |=> status[i]);
    end
endmodule

bind rst_cause_rec rcr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clv0_evt    (clv0_evt),
    .sw_clr_wr   (sw_clr_wr),
    .sw_clr_data (sw_clr_data),
    .hit         (evt_hit),
    .status      (status),
    .reset_req   (reset_req)
);

// File: tb/sim_rst_cause_rec.sv
// Directed bench for rst_cause_rec: one task per scenario.
module sim_rst_cause_rec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic       sw_clr_wr = 1'b0;
    logic [4:0] sw_clr_data = '0;
    logic [4:0] alt_sel = '0;
    logic [4:0] alt_kind = '0;
    logic [4:0] status;
    logic       reset_req, safe_req, irq_req;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rst_cause_rec u0 (
        .clk(clk), .rst_n(rst_n),
        .por_evt(ev[0]), .hv_lv_evt(ev[1]), .wdog_evt(ev[2]),
        .clv1_evt(ev[3]), .clv0_evt(ev[4]),
        .sw_clr_wr(sw_clr_wr), .sw_clr_data(sw_clr_data),
        .alt_sel(alt_sel), .alt_kind(alt_kind),
        .status(status), .reset_req(reset_req),
        .safe_req(safe_req), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [4:0] reqs();
        return {2'b00, reset_req, safe_req, irq_req};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; ev = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 requests idle after reset", reqs(), 5'b00000);
    endtask

    task automatic t_por();
        ev[0] = 1'b1; step();
        chk("R3 power-on sets bit 0 only", status, 5'b00001);
        chk("R12 power-on reset pulse", reqs(), 5'b00100);
        ev[0] = 1'b0; step();
        chk("R12 request lasts one cycle", reqs(), 5'b00000);
    endtask

    task automatic t_wdog_level();
        ev[2] = 1'b1; step();
        chk("R7 watchdog sets on rise", status, 5'b00101);
        chk("R8 watchdog default reset", reqs(), 5'b00100);
        step();
        chk("R7 held level no new request", reqs(), 5'b00000);
        chk("R2 flag sticky", status, 5'b00101);
        sw_clr_wr = 1'b1; sw_clr_data = 5'b00100; step();
        sw_clr_wr = 1'b0; sw_clr_data = '0;
        chk("R5 clear watchdog flag", status, 5'b00001);
        step();
        chk("R7 held level not recaptured", status, 5'b00001);
        ev[2] = 1'b0; step();
        sw_clr_wr = 1'b1; sw_clr_data = 5'b00000; step();
        sw_clr_wr = 1'b0;
        chk("R5 zero mask clears nothing", status, 5'b00001);
    endtask

    task automatic t_clv0();
        ev[4] = 1'b1; step();
        chk("R6 rise of domain-0 ignored (flags)", status, 5'b00001);
        chk("R6 rise of domain-0 ignored (requests)", reqs(), 5'b00000);
        ev[4] = 1'b0; step();
        chk("R6/R4 fall sets bit 4, clears bit 0", status, 5'b10000);
        chk("R6 reset request on fall", reqs(), 5'b00100);
        step();
    endtask

    task automatic t_nonmono();
        ev[0] = 1'b1; step(); ev[0] = 1'b0; step();
        chk("R3 power-on clears other flags", status, 5'b00001);
        ev[1] = 1'b1; step();
        chk("R4 non-monotonic power-up keeps only low-voltage", status, 5'b00010);
        ev[1] = 1'b0; step();
    endtask

    task automatic t_alt();
        alt_sel = 5'b11111; alt_kind = 5'b01000;
        ev[3] = 1'b1; step();
        chk("R8 domain-1 alternate irq", reqs(), 5'b00001);
        chk("R8 domain-1 flag", status, 5'b01010);
        ev[3] = 1'b0; step();
        ev[1] = 1'b1; step();
        chk("R9 high-rail ignores alternate", reqs(), 5'b00100);
        ev[1] = 1'b0; step();
        ev[4] = 1'b1; step();
        chk("R6 alternate not raised on rise", reqs(), 5'b00000);
        ev[4] = 1'b0; step();
        chk("R6 safe request on fall", reqs(), 5'b00010);
        ev[0] = 1'b1; step();
        chk("R9 power-on ignores alternate", reqs(), 5'b00100);
        ev[0] = 1'b0; step();
        alt_sel = '0; alt_kind = '0;
    endtask

    task automatic t_setwins();
        ev[2] = 1'b1; sw_clr_wr = 1'b1; sw_clr_data = 5'b00100; step();
        sw_clr_wr = 1'b0; sw_clr_data = '0;
        chk("R10 set beats clear", status, 5'b00101);
        ev[2] = 1'b0; step();
    endtask

    task automatic t_rst_keep();
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        chk("R11 flags survive rst_n", status, 5'b00101);
        chk("R1 requests idle after rst_n", reqs(), 5'b00000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_por();
        t_wdog_level();
        t_clv0();
        t_nonmono();
        t_alt();
        t_setwins();
        t_rst_keep();
        finish_run();
    end
endmodule